// File: doc/BRIEF.md
# Periodic Local Interrupt Timer

This block is a per-processor down-counting timer reached through a small memory-mapped register window. Software programs a timer entry that holds an interrupt vector, a mask bit and a mode bit. It selects a clock divider and writes a starting count. The counter then steps down once for every divided clock tick. When the count runs out, the block emits a one-cycle interrupt request that carries the programmed vector.

In periodic mode the counter refills from the stored starting count and keeps going, so software gets a steady stream of requests. In one-shot mode it fires once and rests at zero until software writes a new starting count. A masked timer still counts and still refills, but it raises nothing. A control state machine runs the counter and has three states: ST_IDLE (stopped, count zero), ST_COUNT (counting) and ST_EXPIRED (one-shot finished, count zero). Its transitions are:
- LOAD_RUN: any state to ST_COUNT on a nonzero starting-count write, which also restarts counting.
- LOAD_STOP: any state to ST_IDLE on a zero starting-count write.
- RELOAD: ST_COUNT to ST_COUNT on a periodic expiry.
- FINISH: ST_COUNT to ST_EXPIRED on a one-shot expiry.

Top module: `periodic_local_timer`

## Requirements
- R1: After reset the timer entry reads 0x00010000 (masked, one-shot, vector 0), the starting count, current count and divide register read 0, and irq_pulse is low.
- R2: The timer entry at offset 0x320 holds the vector in bits 7:0, the mask in bit 16 and the periodic-mode bit in bit 17; all other bits read back as 0.
- R3: The divide register at offset 0x3E0 keeps bits 3, 1 and 0 as a code {b3,b1,b0}; codes 0 to 6 divide the clock by 2, 4, 8, 16, 32, 64 and 128, and code 7 (value 0xB) divides by 1; other bits read back as 0.
- R4: Writing a nonzero value N to the starting count at offset 0x380 loads N into the current count, restarts the divider, and makes the first request appear N*D cycles after the write edge, where D is the division; a rewrite in mid-count restarts this timing.
- R5: The current count at offset 0x390 reads back the live value, which falls by exactly one for each divided tick.
- R6: On expiry of an unmasked timer, irq_pulse is high for one cycle per expiry and irq_vector carries the vector held in the entry at that moment.
- R7: In periodic mode the counter refills from the starting count on expiry, so requests repeat every N*D cycles.
- R8: In one-shot mode the counter holds at zero after the single request and raises no further request until the starting count is written again.
- R9: With the mask bit set the counter still counts and refills, but irq_pulse stays low.
- R10: Writing zero to the starting count stops the timer with the current count at zero and no request.
- R11: Writes to the current count register are ignored.
- R12: The starting count register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset, used for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the latest request |

## Verification
The hardest situation to reach is an expiry that lands exactly on a divided tick boundary. The two extremes must both work: a pulse in every cycle at divide by one with a count of one, and an expiry spread over 128 cycles per step. The stimulus sweeps all eight divide codes against several small counts in both modes. It measures the cycle distance from the load edge to the first request and between requests. Directed sequences cover the remaining cases: a restart in mid-count, a zero write while running, a masked refill read through the current count, and a write to the read-only count.

// File: rtl/plt_pkg.sv
package plt_pkg;

    // Register byte offsets inside the timer window
    localparam logic [11:0] OFS_ENTRY = 12'h320;
    localparam logic [11:0] OFS_START = 12'h380;
    localparam logic [11:0] OFS_LIVE  = 12'h390;
    localparam logic [11:0] OFS_DIV   = 12'h3E0;

    // Field positions inside the timer entry
    localparam int ENTRY_MASK_BIT = 16;
    localparam int ENTRY_MODE_BIT = 17;
    localparam int VEC_W          = 8;

    // Divide-code bit positions
    localparam int DIV_HI_BIT = 3;
    localparam int DIV_MD_BIT = 1;
    localparam int DIV_LO_BIT = 0;
    localparam logic [2:0] DIV_CODE_BY1 = 3'b111;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXPIRED = 2'd2
    } tmr_state_e;

    typedef struct packed {
        logic             periodic;
        logic             mask;
        logic [VEC_W-1:0] vector;
    } entry_cfg_t;

endpackage

// File: rtl/plt_regs.sv
module plt_regs
    import plt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0]  live_count,
    output logic [DATA_W-1:0] reg_rdata,
    output entry_cfg_t        entry_cfg,
    output logic [CNT_W-1:0]  start_count,
    output logic [2:0]        div_code,
    output logic              load_strobe,
    output logic [CNT_W-1:0]  load_value,
    output logic              div_strobe
);

    logic hit_entry;
    logic hit_start;
    logic hit_live;
    logic hit_div;

    assign hit_entry = (reg_addr == ADDR_W'(OFS_ENTRY));
    assign hit_start = (reg_addr == ADDR_W'(OFS_START));
    assign hit_live  = (reg_addr == ADDR_W'(OFS_LIVE));
    assign hit_div   = (reg_addr == ADDR_W'(OFS_DIV));

    assign load_strobe = reg_wr && hit_start;
    assign div_strobe  = reg_wr && hit_div;
    assign load_value  = reg_wdata[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_cfg.periodic <= 1'b0;
            entry_cfg.mask     <= 1'b1;
            entry_cfg.vector   <= '0;
            start_count        <= '0;
            div_code           <= 3'b000;
        end else if (reg_wr) begin
            if (hit_entry) begin
                entry_cfg.periodic <= reg_wdata[ENTRY_MODE_BIT];
                entry_cfg.mask     <= reg_wdata[ENTRY_MASK_BIT];
                entry_cfg.vector   <= reg_wdata[VEC_W-1:0];
            end
            if (hit_start) begin
                start_count <= reg_wdata[CNT_W-1:0];
            end
            if (hit_div) begin
                div_code <= {reg_wdata[DIV_HI_BIT], reg_wdata[DIV_MD_BIT],
                             reg_wdata[DIV_LO_BIT]};
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_entry) begin
            reg_rdata[ENTRY_MODE_BIT] = entry_cfg.periodic;
            reg_rdata[ENTRY_MASK_BIT] = entry_cfg.mask;
            reg_rdata[VEC_W-1:0]      = entry_cfg.vector;
        end else if (hit_start) begin
            reg_rdata[CNT_W-1:0] = start_count;
        end else if (hit_live) begin
            reg_rdata[CNT_W-1:0] = live_count;
        end else if (hit_div) begin
            reg_rdata[DIV_HI_BIT] = div_code[2];
            reg_rdata[DIV_MD_BIT] = div_code[1];
            reg_rdata[DIV_LO_BIT] = div_code[0];
        end
    end

    // Write-data bits that no field stores
    logic unused_wdata;
    assign unused_wdata = ^reg_wdata;

endmodule

// File: rtl/plt_prescaler.sv
module plt_prescaler
    import plt_pkg::*;
#(
    parameter int DIV_LOG2_MAX = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] div_code,
    input  logic       restart,
    output logic       tick
);

    localparam int PRE_W = DIV_LOG2_MAX;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] term;

    // Terminal value is the division minus one
    function automatic logic [PRE_W-1:0] code_to_term(input logic [2:0] code);
        logic [PRE_W:0] full;
        if (code == DIV_CODE_BY1) begin
            return '0;
        end
        full = (PRE_W+1)'(1) << (int'(code) + 1);
        return PRE_W'(full - (PRE_W+1)'(1));
    endfunction

    assign term = code_to_term(div_code);
    assign tick = (pre_q == term);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/plt_counter.sv
module plt_counter
    import plt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_strobe,
    input  logic [CNT_W-1:0] load_value,
    input  logic [CNT_W-1:0] start_count,
    input  entry_cfg_t       entry_cfg,
    output logic [CNT_W-1:0] live_count,
    output tmr_state_e       state,
    output logic             irq_pulse,
    output logic [VEC_W-1:0] irq_vector
);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             expire;
    logic             pulse_q;
    logic [VEC_W-1:0] vec_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        if (load_strobe) begin
            if (load_value == '0) begin
                state_d = ST_IDLE;              // LOAD_STOP
                cnt_d   = '0;
            end else begin
                state_d = ST_COUNT;             // LOAD_RUN
                cnt_d   = load_value;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_COUNT: begin
                    if (tick) begin
                        if (cnt_q <= CNT_W'(1)) begin
                            expire = 1'b1;
                            if (entry_cfg.periodic) begin
                                cnt_d = start_count;    // RELOAD
                            end else begin
                                cnt_d   = '0;
                                state_d = ST_EXPIRED;   // FINISH
                            end
                        end else begin
                            cnt_d = cnt_q - CNT_W'(1);
                        end
                    end
                end
                ST_EXPIRED: begin
                    state_d = ST_EXPIRED;
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            vec_q   <= '0;
        end else begin
            pulse_q <= expire && !entry_cfg.mask;
            if (expire) begin
                vec_q <= entry_cfg.vector;
            end
        end
    end

    assign live_count = cnt_q;
    assign state      = state_q;
    assign irq_pulse  = pulse_q;
    assign irq_vector = vec_q;

endmodule

// File: rtl/periodic_local_timer.sv
module periodic_local_timer
    import plt_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int DATA_W       = 32,
    parameter int CNT_W        = 32,
    parameter int DIV_LOG2_MAX = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_pulse,
    output logic [VEC_W-1:0]  irq_vector
);

    entry_cfg_t       entry_cfg;
    logic [CNT_W-1:0] start_count;
    logic [CNT_W-1:0] live_count;
    logic [CNT_W-1:0] load_value;
    logic [2:0]       div_code;
    logic             load_strobe;
    logic             div_strobe;
    logic             tick;
    tmr_state_e       state;

    plt_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .live_count (live_count),
        .reg_rdata  (reg_rdata),
        .entry_cfg  (entry_cfg),
        .start_count(start_count),
        .div_code   (div_code),
        .load_strobe(load_strobe),
        .load_value (load_value),
        .div_strobe (div_strobe)
    );

    plt_prescaler #(
        .DIV_LOG2_MAX(DIV_LOG2_MAX)
    ) pre_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_code(div_code),
        .restart (load_strobe || div_strobe),
        .tick    (tick)
    );

    plt_counter #(
        .CNT_W(CNT_W)
    ) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load_strobe(load_strobe),
        .load_value (load_value),
        .start_count(start_count),
        .entry_cfg  (entry_cfg),
        .live_count (live_count),
        .state      (state),
        .irq_pulse  (irq_pulse),
        .irq_vector (irq_vector)
    );

endmodule

// File: rtl/plt_checker.sv
module plt_checker
    import plt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             load_strobe,
    input tmr_state_e       state,
    input logic [CNT_W-1:0] live_count,
    input logic [CNT_W-1:0] start_count,
    input logic             cfg_mask,
    input logic             cfg_periodic,
    input logic [VEC_W-1:0] cfg_vector,
    input logic             irq_pulse,
    input logic [VEC_W-1:0] irq_vector
);

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && tick && !load_strobe && live_count > CNT_W'(1))
        |=> live_count == $past(live_count) - CNT_W'(1)); // R5

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !tick && !load_strobe) |=> $stable(live_count)); // R5

    AST_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && tick && !load_strobe && live_count == CNT_W'(1) && cfg_periodic)
        |=> live_count == $past(start_count)); // R7

    AST_ONESHOT_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXPIRED && !load_strobe)
        |=> (state == ST_EXPIRED && live_count == '0 && !irq_pulse)); // R8

    AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> !$past(cfg_mask)); // R9

    AST_PULSE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> irq_vector == $past(cfg_vector)); // R6

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (live_count == '0 && !irq_pulse)); // R10

endmodule

bind periodic_local_timer plt_checker #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .load_strobe (load_strobe),
    .state       (state),
    .live_count  (live_count),
    .start_count (start_count),
    .cfg_mask    (entry_cfg.mask),
    .cfg_periodic(entry_cfg.periodic),
    .cfg_vector  (entry_cfg.vector),
    .irq_pulse   (irq_pulse),
    .irq_vector  (irq_vector)
);

// File: tb/periodic_local_timer_tb_top.sv
`timescale 1ns/1ps
module periodic_local_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = 12'h000;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_pulse;
    logic [7:0]  irq_vector;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    periodic_local_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_pulse (irq_pulse),
        .irq_vector(irq_vector)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual cycles %0d expected end before 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge right after the write edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Counts negedges until a pulse is seen; k = edges since reference
    task automatic wait_pulse(input int limit, output int k);
        k = 0;
        while (k < limit) begin
            @(negedge clk);
            k++;
            if (irq_pulse) break;
        end
    endtask

    function automatic int div_of(input int code);
        return (code == 7) ? 1 : (2 << code);
    endfunction

    function automatic logic [31:0] div_word(input int code);
        logic [2:0] c;
        c = 3'(code);
        return {28'd0, c[2], 1'b0, c[1], c[0]};
    endfunction

    task automatic sweep_case(input int code, input int n, input bit periodic);
        int d;
        int k;
        int quiet;
        logic [7:0] vec;
        logic [31:0] r;
        d   = div_of(code);
        vec = 8'(8'h40 + code * 8 + n);
        wr(12'h3E0, div_word(code));
        wr(12'h320, {14'd0, periodic, 1'b0, 8'd0, vec});
        wr(12'h380, 32'(n));
        wait_pulse(n * d + 10, k);
        chk(k == n * d, "R4 first expiry delay", 32'(k), 32'(n * d));
        chk(irq_vector == vec, "R6 vector on expiry", 32'(irq_vector), 32'(vec));
        if (periodic) begin
            wait_pulse(n * d + 10, k);
            chk(k == n * d, "R7 periodic interval", 32'(k), 32'(n * d));
        end else begin
            quiet = 0;
            for (int i = 0; i < 2 * n * d + 4; i++) begin
                @(negedge clk);
                if (irq_pulse) quiet++;
            end
            chk(quiet == 0, "R8 one-shot no further pulse", 32'(quiet), 32'd0);
            rd(12'h390, r);
            chk(r == 32'd0, "R8 one-shot rests at zero", r, 32'd0);
        end
    endtask

    initial begin
        logic [31:0] r;
        int k;
        int hits;
        int ns[4];
        ns = '{1, 2, 3, 5};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h320, r); chk(r == 32'h00010000, "R1 entry reset", r, 32'h00010000);
        rd(12'h380, r); chk(r == 32'd0, "R1 start count reset", r, 32'd0);
        rd(12'h390, r); chk(r == 32'd0, "R1 live count reset", r, 32'd0);
        rd(12'h3E0, r); chk(r == 32'd0, "R1 divide reset", r, 32'd0);
        chk(irq_pulse == 1'b0, "R1 no request at reset", 32'(irq_pulse), 32'd0);

        // R2 entry fields
        wr(12'h320, 32'hFFFFFFFF);
        rd(12'h320, r); chk(r == 32'h000300FF, "R2 entry field readback", r, 32'h000300FF);
        wr(12'h320, 32'h00020041);
        rd(12'h320, r); chk(r == 32'h00020041, "R2 entry periodic vector 0x41", r, 32'h00020041);

        // R3 divide code bits
        wr(12'h3E0, 32'hFFFFFFFF);
        rd(12'h3E0, r); chk(r == 32'h0000000B, "R3 divide readback", r, 32'h0000000B);

        // R12 start count readback
        wr(12'h380, 32'h00000000);
        wr(12'h380, 32'h12345678);
        rd(12'h380, r); chk(r == 32'h12345678, "R12 start count readback", r, 32'h12345678);
        wr(12'h380, 32'h00000000);

        // R5 live decrement at divide 1, then R11 ignored write
        wr(12'h3E0, 32'h0000000B);
        wr(12'h320, 32'h00020041);
        wr(12'h380, 32'd10);
        repeat (3) @(negedge clk);
        rd(12'h390, r); chk(r == 32'd7, "R5 live count after 3 ticks", r, 32'd7);
        wr(12'h390, 32'h00000055);
        rd(12'h390, r); chk(r == 32'd6, "R11 live count write ignored", r, 32'd6);

        // R5 decrement rate at divide 4 (code 001)
        wr(12'h3E0, 32'h00000001);
        wr(12'h380, 32'd3);
        repeat (3) @(negedge clk);
        rd(12'h390, r); chk(r == 32'd3, "R5 no step before divided tick", r, 32'd3);
        @(negedge clk);
        rd(12'h390, r); chk(r == 32'd2, "R5 step on divided tick", r, 32'd2);

        // R9 masked periodic: counts and refills, no pulse
        wr(12'h3E0, 32'h0000000B);
        wr(12'h320, 32'h00030041);
        wr(12'h380, 32'd4);
        hits = 0;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            if (irq_pulse) hits++;
            if (i == 5) begin
                rd(12'h390, r);
                chk(r == 32'd3, "R9 masked timer refilled and counting", r, 32'd3);
            end
        end
        chk(hits == 0, "R9 masked timer silent", 32'(hits), 32'd0);

        // R10 zero write stops a running timer
        wr(12'h320, 32'h00020041);
        wr(12'h380, 32'd3);
        @(negedge clk);
        wr(12'h380, 32'd0);
        hits = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (irq_pulse) hits++;
        end
        chk(hits == 0, "R10 stopped timer silent", 32'(hits), 32'd0);
        rd(12'h390, r); chk(r == 32'd0, "R10 stopped live count", r, 32'd0);

        // R4 restart in mid-count
        wr(12'h380, 32'd8);
        repeat (5) @(negedge clk);
        wr(12'h380, 32'd8);
        wait_pulse(30, k);
        chk(k == 8, "R4 restart re-times expiry", 32'(k), 32'd8);

        // R8 one-shot re-armed by a new start count
        wr(12'h320, 32'h00000033);
        wr(12'h380, 32'd2);
        wait_pulse(20, k);
        chk(k == 2, "R8 one-shot first expiry", 32'(k), 32'd2);
        repeat (6) @(negedge clk);
        wr(12'h380, 32'd3);
        wait_pulse(20, k);
        chk(k == 3, "R8 one-shot re-armed", 32'(k), 32'd3);
        chk(irq_vector == 8'h33, "R6 one-shot vector", 32'(irq_vector), 32'h33);

        // R3 R4 R7 R8 sweep over all divide codes and small counts
        for (int code = 0; code < 8; code++) begin
            for (int j = 0; j < 4; j++) begin
                sweep_case(code, ns[j], 1'b1);
                sweep_case(code, ns[j], 1'b0);
            end
        end

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule